// File: doc/BRIEF.md
# Multi-Device EPROM Read Controller

This block serves single-byte read requests from a host and fetches them from a bank of byte-wide asynchronous EPROMs that share one address bus and one data bus. The upper bits of the host address pick a device. That device gets its own active-low chip enable. A single active-low output enable is wired to every device in the bank and acts as the read strobe. Devices whose chip enable is high stay in low-power standby.

The controller counts clock cycles so that three delays are met before data is captured: address to output, chip enable to output, and output enable to output. Output enable is deliberately asserted late, by the difference between the address and output-enable access times. Data is therefore still valid at the address deadline. When a read moves to a different device, every enable is held high for the output float time first, so the previous device releases the bus before the new one can drive it. Reads that stay on the same device keep the chip enable low and sequence only the address and output enable.

The host side is a valid/ready request with a byte address and a one-cycle response strobe carrying the data. All timing figures come from a speed-grade parameter and the clock frequency.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, every chip enable is high, output enable is high, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: At most one chip enable is low at any time. The low one has index equal to the request address bits above the device offset, so address bit DEV_ADDR_W upward selects the device.
- R3: Output enable is low only while a chip enable is low. It falls OE_DLY = ACC_CYC - OE_CYC cycles after the cycle in which the read's chip enable and address are first driven together.
- R4: The response byte equals the data bus value of the selected device at the requested offset. It is captured ACC_CYC cycles after chip enable and address are both driven. `rsp_valid_o` is high for exactly one cycle per read.
- R5: Each wait count is ceil(t_ns * CLK_MHZ / 1000) + 1. For speed grade 0 the times are 55 ns address, 55 ns chip enable, 30 ns output enable and 30 ns float. For grade 1 they are 100/100/50/30 ns, and for grade 2 they are 150/150/60/50 ns. At 250 MHz, grade 0 gives ACC_CYC = 15, OE_CYC = 9 and FLT_CYC = 9.
- R6: A read to a device other than the one whose chip enable is low first raises all chip enables for FLT_CYC cycles. The response then arrives FLT_CYC + ACC_CYC cycles after acceptance, and no device starts driving the bus within the float time of another.
- R7: A read to the device whose chip enable is already low keeps that enable low throughout. Its response arrives ACC_CYC cycles after acceptance.
- R8: The first read after reset needs no float interval, and its response arrives ACC_CYC cycles after acceptance.
- R9: Output enable is high in the cycle the response is presented.
- R10: `req_ready_o` is low from the cycle after acceptance until the response cycle. The device address does not change during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host read request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | DEV_ADDR_W+log2(NUM_DEV) | Host byte address; top bits select the device |
| rsp_valid_o | output | 1 | One-cycle strobe: response data valid |
| rsp_data_o | output | DATA_W | Byte read from the device |
| mem_addr_o | output | DEV_ADDR_W | Shared device address bus |
| mem_ce_n_o | output | NUM_DEV | Active-low chip enable, one per device |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_data_i | input | DATA_W | Shared device data bus |

## Verification
Two things can happen in the same cycle: a response is delivered, and the next request is accepted. That next request may also force a device switch. The switch raises the chip enable just after output enable rose, so the float window must be counted from the later of the two. The bench provokes this by presenting each new request in the very cycle the previous response appears, with a random device choice that switches or stays about half the time.

The bench models the devices cycle by cycle. A device returns its byte only once the address, chip-enable and output-enable ages all cover the access times. The model also flags any device that starts driving inside another device's float time. Each read is judged on its data, its latency, the number of cycles with all enables high, and the cycle in which output enable falls.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FLOAT  = 2'd1,
      ST_ACCESS = 2'd2
   } rd_state_e;

   // access times per speed grade, in ns
   function automatic int t_addr_ns(input int grade);
      case (grade)
         0:       return 55;
         1:       return 100;
         default: return 150;
      endcase
   endfunction

   function automatic int t_oe_ns(input int grade);
      case (grade)
         0:       return 30;
         1:       return 50;
         default: return 60;
      endcase
   endfunction

   function automatic int t_float_ns(input int grade);
      case (grade)
         0, 1:    return 30;
         default: return 50;
      endcase
   endfunction

   // ceiling of cycles covering t_ns, plus one sampling cycle
   function automatic int wait_cycles(input int t_ns, input int clk_mhz);
      return (t_ns * clk_mhz + 999) / 1000 + 1;
   endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/eprom_rd_ce_dec.sv
module eprom_rd_ce_dec #(
   parameter int NUM_DEV = 4,
   parameter int SEL_W   = 2
) (
   input  logic               en,
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_DEV-1:0] ce_n
);

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
      assign ce_n[g] = !(en && (sel == SEL_W'(g)));
   end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
   import eprom_rd_pkg::*;
#(
   parameter int NUM_DEV     = 4,
   parameter int DEV_ADDR_W  = 18,
   parameter int DATA_W      = 8,
   parameter int CLK_MHZ     = 250,
   parameter int SPEED_GRADE = 0,
   localparam int SEL_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int ADDR_W     = DEV_ADDR_W + SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [ADDR_W-1:0]  req_addr_i,
   output logic               rsp_valid_o,
   output logic [DATA_W-1:0]  rsp_data_o,
   output logic [DEV_ADDR_W-1:0] mem_addr_o,
   output logic [NUM_DEV-1:0] mem_ce_n_o,
   output logic               mem_oe_n_o,
   input  logic [DATA_W-1:0]  mem_data_i
);

   localparam int ACC_CYC = wait_cycles(t_addr_ns(SPEED_GRADE), CLK_MHZ);
   localparam int OE_CYC  = wait_cycles(t_oe_ns(SPEED_GRADE), CLK_MHZ);
   localparam int FLT_CYC = wait_cycles(t_float_ns(SPEED_GRADE), CLK_MHZ);
   localparam int OE_DLY  = ACC_CYC - OE_CYC;
   localparam int CNT_MAX = (ACC_CYC > FLT_CYC) ? ACC_CYC : FLT_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] FLT_LAST = CNT_W'(FLT_CYC - 1);
   localparam logic [CNT_W-1:0] OE_HIT   = CNT_W'((OE_DLY > 0) ? OE_DLY - 1 : 0);
   localparam logic OE_LATE = (OE_DLY > 0);

   // elaboration checks
   if (NUM_DEV < 2 || (1 << SEL_W) != NUM_DEV) begin : g_bad_ndev
      $error("NUM_DEV must be a power of two, at least 2");
   end
   if (SPEED_GRADE < 0 || SPEED_GRADE > 2) begin : g_bad_grade
      $error("SPEED_GRADE must be 0, 1 or 2");
   end
   if (OE_CYC > ACC_CYC) begin : g_bad_oe
      $error("output enable wait exceeds address wait");
   end
   if (DATA_W < 1 || DEV_ADDR_W < 1 || CLK_MHZ < 1) begin : g_bad_w
      $error("widths and clock must be positive");
   end

   rd_state_e            state_q, state_d;
   logic [SEL_W-1:0]     sel_q, sel_d;
   logic                 ce_en_q, ce_en_d;
   logic                 oe_n_q, oe_n_d;
   logic [DEV_ADDR_W-1:0] addr_q, addr_d;
   logic                 rsp_v_q, rsp_v_d;
   logic [DATA_W-1:0]    rsp_data_q, rsp_data_d;
   logic [NUM_DEV-1:0]   ce_n_q, ce_n_d;
   logic                 tmr_clr, tmr_en;
   logic [CNT_W-1:0]     cnt;
   logic [SEL_W-1:0]     req_sel;

   assign req_sel = req_addr_i[ADDR_W-1 -: SEL_W];

   eprom_rd_timer #(.CNT_W(CNT_W)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .en    (tmr_en),
      .cnt   (cnt)
   );

   eprom_rd_ce_dec #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) dec_i (
      .en   (ce_en_d),
      .sel  (sel_d),
      .ce_n (ce_n_d)
   );

   always_comb begin
      state_d    = state_q;
      sel_d      = sel_q;
      ce_en_d    = ce_en_q;
      oe_n_d     = oe_n_q;
      addr_d     = addr_q;
      rsp_v_d    = 1'b0;
      rsp_data_d = rsp_data_q;
      tmr_clr    = 1'b0;
      tmr_en     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid_i) begin
               addr_d  = req_addr_i[DEV_ADDR_W-1:0];
               sel_d   = req_sel;
               tmr_clr = 1'b1;
               if (ce_en_q && (req_sel != sel_q)) begin
                  ce_en_d = 1'b0;
                  state_d = ST_FLOAT;
               end else begin
                  ce_en_d = 1'b1;
                  oe_n_d  = OE_LATE;
                  state_d = ST_ACCESS;
               end
            end
         end
         ST_FLOAT: begin
            tmr_en = 1'b1;
            if (cnt == FLT_LAST) begin
               tmr_clr = 1'b1;
               ce_en_d = 1'b1;
               oe_n_d  = OE_LATE;
               state_d = ST_ACCESS;
            end
         end
         ST_ACCESS: begin
            tmr_en = 1'b1;
            if (OE_LATE && cnt == OE_HIT) oe_n_d = 1'b0;
            if (cnt == ACC_LAST) begin
               rsp_v_d    = 1'b1;
               rsp_data_d = mem_data_i;
               oe_n_d     = 1'b1;
               state_d    = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         sel_q      <= '0;
         ce_en_q    <= 1'b0;
         oe_n_q     <= 1'b1;
         addr_q     <= '0;
         rsp_v_q    <= 1'b0;
         rsp_data_q <= '0;
         ce_n_q     <= '1;
      end else begin
         state_q    <= state_d;
         sel_q      <= sel_d;
         ce_en_q    <= ce_en_d;
         oe_n_q     <= oe_n_d;
         addr_q     <= addr_d;
         rsp_v_q    <= rsp_v_d;
         rsp_data_q <= rsp_data_d;
         ce_n_q     <= ce_n_d;
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign rsp_valid_o = rsp_v_q;
   assign rsp_data_o  = rsp_data_q;
   assign mem_addr_o  = addr_q;
   assign mem_ce_n_o  = ce_n_q;
   assign mem_oe_n_o  = oe_n_q;

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
   parameter int NUM_DEV    = 4,
   parameter int DEV_ADDR_W = 18
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_ready,
   input logic                  rsp_valid,
   input logic [DEV_ADDR_W-1:0] mem_addr,
   input logic [NUM_DEV-1:0]    ce_n,
   input logic                  oe_n
);

   a_r2_one_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ce_n));

   a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !(&ce_n));

   a_r4_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r6_ce_fall_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((~ce_n & $past(ce_n)) != '0) |-> (&$past(ce_n)));

   a_r9_oe_high_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> oe_n);

   a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
   .NUM_DEV    (NUM_DEV),
   .DEV_ADDR_W (DEV_ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready_o),
   .rsp_valid (rsp_valid_o),
   .mem_addr  (mem_addr_o),
   .ce_n      (mem_ce_n_o),
   .oe_n      (mem_oe_n_o)
);

// File: tb/eprom_rd_ctrl_tb_top.sv
module eprom_rd_ctrl_tb_top;

   localparam int NDEV  = 4;
   localparam int DAW   = 18;
   localparam int AW    = DAW + 2;
   localparam int PER   = 4;     // ns, 250 MHz
   localparam int MHZ   = 250;
   localparam int T_ACC = 55;
   localparam int T_OE  = 30;
   localparam int T_FLT = 30;

   function automatic int cyc(input int t);
      return (t * MHZ + 999) / 1000 + 1;
   endfunction

   localparam int ACC = cyc(T_ACC);
   localparam int OEC = cyc(T_OE);
   localparam int FLT = cyc(T_FLT);
   localparam int OED = ACC - OEC;

   function automatic logic [7:0] mem_byte(input int dev, input int a);
      return 8'((a * 7) + (dev * 53) + (a >> 8) + (a >> 13));
   endfunction

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [AW-1:0]  req_addr = '0;
   logic           rsp_valid;
   logic [7:0]     rsp_data;
   logic [DAW-1:0] mem_addr;
   logic [NDEV-1:0] ce_n;
   logic           oe_n;
   logic [7:0]     mem_data = 8'h00;

   int checks = 0;
   int fails  = 0;
   int last_dev = -1;
   bit done = 1'b0;

   always #(PER/2) clk = ~clk;

   eprom_rd_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid),
      .req_ready_o (req_ready),
      .req_addr_i  (req_addr),
      .rsp_valid_o (rsp_valid),
      .rsp_data_o  (rsp_data),
      .mem_addr_o  (mem_addr),
      .mem_ce_n_o  (ce_n),
      .mem_oe_n_o  (oe_n),
      .mem_data_i  (mem_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // device bank model, evaluated between clock edges
   int age_a, age_c, age_o, gap, drv;
   bit was_drv;
   logic [DAW-1:0]  p_a;
   logic [NDEV-1:0] p_c;
   logic            p_o;

   always @(negedge clk) begin
      int cur;
      bit driving;
      if (!rst_n) begin
         age_a = 1000; age_c = 1000; age_o = 1000; gap = 1000;
         drv = -1; was_drv = 1'b0;
         p_a = mem_addr; p_c = ce_n; p_o = oe_n;
         mem_data = 8'h00;
      end else begin
         age_a = (mem_addr != p_a) ? 1 : ((age_a < 1000) ? age_a + 1 : age_a);
         age_c = (ce_n != p_c) ? 1 : ((age_c < 1000) ? age_c + 1 : age_c);
         age_o = (oe_n != p_o) ? 1 : ((age_o < 1000) ? age_o + 1 : age_o);
         p_a = mem_addr; p_c = ce_n; p_o = oe_n;
         cur = -1;
         for (int i = 0; i < NDEV; i++) if (!ce_n[i] && cur < 0) cur = i;
         driving = (cur >= 0) && !oe_n;
         if (driving && !was_drv) begin
            if (drv >= 0 && drv != cur)
               chk(gap * PER >= T_FLT, "R6 bus float before new driver", gap * PER, T_FLT);
            drv = cur;
         end
         gap = driving ? 0 : ((gap < 1000) ? gap + 1 : gap);
         was_drv = driving;
         if (!driving)
            mem_data = 8'h00;
         else if (age_a * PER >= T_ACC && age_c * PER >= T_ACC && age_o * PER >= T_OE)
            mem_data = mem_byte(cur, int'(mem_addr));
         else
            mem_data = mem_byte(cur, int'(mem_addr)) ^ 8'h5A;
      end
   end

   // issue one read at a negedge; returns at the negedge showing the response
   task automatic do_read(input int dev, input int off);
      int k, ce_hi, oe_k, exp_lat, exp_hi;
      bit sw;
      string tag;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'((dev << DAW) | off);
      sw = (last_dev >= 0) && (last_dev != dev);
      tag = (last_dev < 0) ? "R8" : (sw ? "R6" : "R7");
      @(posedge clk);
      k = 0; ce_hi = 0; oe_k = -1;
      forever begin
         @(negedge clk);
         req_valid = 1'b0;
         if (rsp_valid) break;
         if (k == 0) chk(!req_ready, "R10 ready low while busy", req_ready, 0);
         if (&ce_n) ce_hi++;
         if (!oe_n && oe_k < 0) begin
            oe_k = k;
            chk(!ce_n[dev] && $countones(~ce_n) == 1, "R2 selected chip enable",
                int'(ce_n), int'(~(NDEV'(1) << dev)));
         end
         k++;
         if (k > 200) break;
      end
      exp_hi  = sw ? FLT : 0;
      exp_lat = exp_hi + ACC;
      chk(k == exp_lat, {tag, " R5 response latency"}, k, exp_lat);
      chk(ce_hi == exp_hi, {tag, " all-enables-high cycles"}, ce_hi, exp_hi);
      chk(oe_k == exp_hi + OED, "R3 output enable fall cycle", oe_k, exp_hi + OED);
      chk(rsp_data == mem_byte(dev, off), "R4 response data", rsp_data, mem_byte(dev, off));
      chk(oe_n, "R9 output enable high at response", oe_n, 1);
      last_dev = dev;
   endtask

   initial begin
      int dev, off;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(&ce_n, "R1 chip enables high in reset", int'(ce_n), 15);
      chk(oe_n && req_ready && !rsp_valid, "R1 oe/ready/rsp in reset",
          {oe_n, req_ready, rsp_valid}, 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(&ce_n && oe_n && req_ready && !rsp_valid, "R1 idle after reset",
          {ce_n, oe_n, req_ready, rsp_valid}, 7'b1111110);
      chk(ACC == 15 && OEC == 9 && FLT == 9, "R5 grade 0 wait counts", ACC * 100 + FLT, 1509);

      // directed corners
      do_read(0, 18'h00123);           // first read, R8
      do_read(0, 18'h3FFFF);           // same device, R7
      do_read(2, 18'h00000);           // switch, R6
      repeat (3) @(negedge clk);
      do_read(2, 18'h2AAAA);           // same device after idle gap
      do_read(3, 18'h3FFFF);           // switch back-to-back
      do_read(1, 18'h00001);
      do_read(1, 18'h15555);

      // random mix
      for (int n = 0; n < 60; n++) begin
         dev = (($urandom % 2) == 0 && last_dev >= 0) ? last_dev : int'($urandom % NDEV);
         off = int'($urandom % (1 << DAW));
         if (($urandom % 4) == 0) repeat ($urandom % 4) @(negedge clk);
         do_read(dev, off);
      end

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule